// File: doc/BRIEF.md
# Float exponent-mantissa split unit

This unit takes one IEEE-754 single-precision operand and splits it for the range-reduction step that comes before a reciprocal, square-root, reciprocal-square-root or logarithm kernel. Depending on the selected operation it returns either a float whose magnitude has been moved into the interval that the following kernel expects, or a signed 32-bit integer exponent that the kernel adds back after its polynomial or iteration step. Each operation uses its own interval and its own exponent formula. The square-root variants scale by a power of four, so the chosen scale depends on the parity of the exponent.

Below, an operand is written as m * 2^e with m in [1, 2). Subnormal operands are first normalised with a leading-zero count, so they get the same treatment as normal numbers. Zero, infinity and NaN are handled separately. The result passes through a single register stage. A valid strobe that travels with the data marks the cycles that carry a result.

Top module: `fsplit_unit`

## Requirements
- R1: Operation code 0 (reciprocal mantissa): for a finite nonzero operand, the result keeps the operand's sign bit and normalised fraction, and its exponent field is 126, so its magnitude lies in [0.5, 1).
- R2: Operation code 1 (square-root mantissa): the result keeps sign and normalised fraction. Its exponent field is 125 (scale 2^-2) when e is even and 126 (scale 2^-1) when e is odd, so its magnitude lies in [0.25, 1).
- R3: The log split writes the operand as x1 * 2^s with x1 in [0.75, 1.5). When the fraction's top bit is 0 (m < 1.5), x1 has exponent field 127 and s = e. When it is 1, x1 has exponent field 126 and s = e + 1. Code 2 returns x1 and code 6 returns s as a 32-bit two's-complement integer.
- R4: Operation code 3 (reciprocal exponent) returns -e - 1 as a 32-bit two's-complement integer.
- R5: Operation code 4 returns floor(e/2) + 1 and code 5 returns -floor(e/2) - 1. floor rounds toward minus infinity for negative odd e.
- R6: In every exponent operation (codes 3 to 6), a zero (of either sign), infinite or NaN operand produces integer 0.
- R7: A subnormal operand with fraction f is treated as having e = -127 - lz, where lz is the number of leading zeros of the 23-bit f. Its fraction is f shifted left by lz + 1, with the leading one dropped.
- R8: In the mantissa operations (codes 0 to 2), zero and infinity operands are returned bit for bit unchanged. A NaN is returned with its fraction bit 22 forced to 1 and all other bits unchanged.
- R9: Operation code 7 returns 0.
- R10: valid_out equals valid_in delayed by one clock. result_out takes a new value only in the cycle after valid_in is 1, and holds its value while valid_in is 0.
- R11: While rst_n is low, valid_out is 0 and result_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Operand and operation select are valid this cycle |
| op_sel | input | 3 | Operation code 0..7 (see requirements) |
| operand_in | input | 32 | Single-precision operand |
| valid_out | output | 1 | result_out carries a new result |
| result_out | output | 32 | Float mantissa or two's-complement integer exponent |

## Verification
The corner that is hardest to reach from the ports is the subnormal path: the leading-zero count, the shift that drops the hidden one and the parity of an exponent far below -126 all have to line up at once. The stimulus uses the smallest subnormal, a subnormal whose top fraction bit is set (e = -127, an odd value that exercises floor toward minus infinity) and one whose second fraction bit also crosses the 1.5 log threshold. Each of these operands is sent through both mantissa and exponent operations.

// File: rtl/fsplit_pkg.sv
package fsplit_pkg;

    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
    localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int unsigned UNB_W  = EXP_W + 2;
    localparam int unsigned LZ_W   = $clog2(FRAC_W + 1);

    localparam logic signed [UNB_W-1:0] BIAS_S    = UNB_W'(BIAS);
    localparam logic [EXP_W-1:0]        EXP_ONE     = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0]        EXP_HALF    = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0]        EXP_QUARTER = EXP_W'(BIAS - 2);

    typedef enum logic [2:0] {
        OP_RCP_MANT  = 3'd0,
        OP_SQRT_MANT = 3'd1,
        OP_LOG_MANT  = 3'd2,
        OP_RCP_EXP   = 3'd3,
        OP_SQRT_EXP  = 3'd4,
        OP_RSQ_EXP   = 3'd5,
        OP_LOG_EXP   = 3'd6,
        OP_NONE      = 3'd7
    } fsplit_op_e;

    typedef struct packed {
        logic                     sign;
        logic                     is_zero;
        logic                     is_inf;
        logic                     is_nan;
        logic [FRAC_W-1:0]        frac;
        logic signed [UNB_W-1:0]  e;
    } fsplit_operand_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
    } fsplit_state_t;

endpackage

// File: rtl/fsplit_lzc.sv
module fsplit_lzc #(
    parameter int unsigned W  = 23,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_in,
    output logic [CW-1:0] zeros_out
);

    always_comb begin
        zeros_out = CW'(W);
        for (int i = 0; i < int'(W); i++) begin
            if (vec_in[i]) begin
                zeros_out = CW'(int'(W) - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fsplit_decode.sv
module fsplit_decode
    import fsplit_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output fsplit_operand_t   dec_out
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [LZ_W-1:0]   lz;
    logic [FRAC_W-1:0] shifted;
    logic              exp_all0;
    logic              exp_all1;
    logic              frac_nz;

    assign exp_f    = word_in[WORD_W-2 -: EXP_W];
    assign frac_f   = word_in[FRAC_W-1:0];
    assign exp_all0 = (exp_f == '0);
    assign exp_all1 = (exp_f == '1);
    assign frac_nz  = (frac_f != '0);

    fsplit_lzc #(
        .W  (FRAC_W),
        .CW (LZ_W)
    ) u_lzc (
        .vec_in    (frac_f),
        .zeros_out (lz)
    );

    assign shifted = frac_f << lz;

    always_comb begin
        dec_out         = '0;
        dec_out.sign    = word_in[WORD_W-1];
        dec_out.is_zero = exp_all0 && !frac_nz;
        dec_out.is_inf  = exp_all1 && !frac_nz;
        dec_out.is_nan  = exp_all1 && frac_nz;
        if (exp_all0) begin
            // subnormal: shift out the leading one, rebase the exponent
            dec_out.frac = {shifted[FRAC_W-2:0], 1'b0};
            dec_out.e    = -BIAS_S - $signed({{(UNB_W-LZ_W){1'b0}}, lz});
        end else begin
            dec_out.frac = frac_f;
            dec_out.e    = $signed({2'b00, exp_f}) - BIAS_S;
        end
    end

endmodule

// File: rtl/fsplit_unit.sv
module fsplit_unit
    import fsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [2:0]        op_sel,
    input  logic [WORD_W-1:0] operand_in,
    output logic              valid_out,
    output logic [WORD_W-1:0] result_out
);

    fsplit_operand_t         dec;
    fsplit_state_t           state_d;
    fsplit_state_t           state_q;
    fsplit_op_e              op;
    logic signed [UNB_W-1:0] half_e;
    logic signed [UNB_W-1:0] int_res;
    logic [WORD_W-1:0]       res;
    logic                    special;
    logic                    mant_op;
    logic                    log_up;

    fsplit_decode u_decode (
        .word_in (operand_in),
        .dec_out (dec)
    );

    assign op      = fsplit_op_e'(op_sel);
    assign special = dec.is_zero || dec.is_inf || dec.is_nan;
    assign mant_op = (op == OP_RCP_MANT) || (op == OP_SQRT_MANT) || (op == OP_LOG_MANT);
    assign half_e  = dec.e >>> 1;
    assign log_up  = dec.frac[FRAC_W-1];

    always_comb begin
        int_res = '0;
        res     = '0;
        case (op)
            OP_RCP_MANT:  res = {dec.sign, EXP_HALF, dec.frac};
            OP_SQRT_MANT: res = {dec.sign, (dec.e[0] ? EXP_HALF : EXP_QUARTER), dec.frac};
            OP_LOG_MANT:  res = {dec.sign, (log_up ? EXP_HALF : EXP_ONE), dec.frac};
            OP_RCP_EXP:   int_res = -dec.e - UNB_W'(1);
            OP_SQRT_EXP:  int_res = half_e + UNB_W'(1);
            OP_RSQ_EXP:   int_res = -half_e - UNB_W'(1);
            OP_LOG_EXP:   int_res = dec.e + $signed({{(UNB_W-1){1'b0}}, log_up});
            default:      int_res = '0;
        endcase
        if (!mant_op) begin
            res = {{(WORD_W-UNB_W){int_res[UNB_W-1]}}, int_res};
        end
        if (special) begin
            if (mant_op) begin
                res = operand_in;
                if (dec.is_nan) begin
                    res[FRAC_W-1] = 1'b1;
                end
            end else begin
                res = '0;
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = valid_in;
        if (valid_in) begin
            state_d.result = res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_out  = state_q.valid;
    assign result_out = state_q.result;

endmodule

// File: rtl/fsplit_unit_chk.sv
module fsplit_unit_chk
    import fsplit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [2:0]        op_sel,
    input logic [WORD_W-1:0] operand_in,
    input logic              valid_out,
    input logic [WORD_W-1:0] result_out
);

    logic in_special;
    logic in_nan;
    logic in_mant;
    logic in_exp;

    assign in_special = (operand_in[WORD_W-2 -: EXP_W] == '1) || (operand_in[WORD_W-2:0] == '0);
    assign in_nan     = (operand_in[WORD_W-2 -: EXP_W] == '1) && (operand_in[FRAC_W-1:0] != '0);
    assign in_mant    = (op_sel <= 3'd2);
    assign in_exp     = (op_sel >= 3'd3) && (op_sel <= 3'd6);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out) else $error("valid_out missing"); // R10

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out) else $error("spurious valid_out"); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result_out)) else $error("result changed while idle"); // R10

    AST_RCP_MANT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 3'd0 && !in_special) |=> (result_out[WORD_W-2 -: EXP_W] == EXP_HALF))
        else $error("reciprocal mantissa out of range"); // R1

    AST_EXP_SPECIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && in_exp && in_special) |=> (result_out == '0))
        else $error("special operand gave nonzero exponent"); // R6

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && in_mant && in_nan) |=> (result_out[FRAC_W-1] && result_out[WORD_W-2 -: EXP_W] == '1))
        else $error("NaN not quieted"); // R8

    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && in_mant) |=> (result_out[WORD_W-1] == $past(operand_in[WORD_W-1])))
        else $error("sign lost on mantissa output"); // R8

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 3'd7) |=> (result_out == '0))
        else $error("unused code gave nonzero"); // R9

endmodule

bind fsplit_unit fsplit_unit_chk u_fsplit_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .op_sel     (op_sel),
    .operand_in (operand_in),
    .valid_out  (valid_out),
    .result_out (result_out)
);

// File: tb/fsplit_unit_bench.sv
`timescale 1ns/1ps
module fsplit_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] operand_in = 32'd0;
    logic        valid_out;
    logic [31:0] result_out;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    fsplit_unit u_fsplit_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .op_sel     (op_sel),
        .operand_in (operand_in),
        .valid_out  (valid_out),
        .result_out (result_out)
    );

    // {requirement number, op code, operand, expected}
    localparam int NV = 34;
    localparam logic [70:0] VECS [NV] = '{
        {4'd1,  3'd0, 32'h3F800000, 32'h3F000000}, // R1 1.0
        {4'd1,  3'd0, 32'hC0400000, 32'hBF400000}, // R1 -3.0
        {4'd2,  3'd1, 32'h40800000, 32'h3E800000}, // R2 4.0 even
        {4'd2,  3'd1, 32'h40000000, 32'h3F000000}, // R2 2.0 odd
        {4'd2,  3'd1, 32'h3F000000, 32'h3F000000}, // R2 0.5 odd negative
        {4'd3,  3'd2, 32'h3F800000, 32'h3F800000}, // R3 1.0
        {4'd3,  3'd2, 32'h3FC00000, 32'h3F400000}, // R3 1.5 threshold
        {4'd3,  3'd6, 32'h3FC00000, 32'h00000001}, // R3 s for 1.5
        {4'd3,  3'd6, 32'h40400000, 32'h00000002}, // R3 s for 3.0
        {4'd3,  3'd6, 32'h3E800000, 32'hFFFFFFFE}, // R3 s for 0.25
        {4'd4,  3'd3, 32'h3F800000, 32'hFFFFFFFF}, // R4 1.0
        {4'd4,  3'd3, 32'h41000000, 32'hFFFFFFFC}, // R4 8.0
        {4'd4,  3'd3, 32'h3E800000, 32'h00000001}, // R4 0.25
        {4'd4,  3'd3, 32'h7F000000, 32'hFFFFFF80}, // R4 largest exponent
        {4'd5,  3'd4, 32'h41000000, 32'h00000002}, // R5 8.0
        {4'd5,  3'd4, 32'h3F000000, 32'h00000000}, // R5 0.5 floor
        {4'd5,  3'd5, 32'h3E000000, 32'h00000001}, // R5 0.125 floor
        {4'd5,  3'd5, 32'h40800000, 32'hFFFFFFFE}, // R5 4.0
        {4'd6,  3'd3, 32'h00000000, 32'h00000000}, // R6 zero
        {4'd6,  3'd4, 32'h7F800000, 32'h00000000}, // R6 infinity
        {4'd6,  3'd6, 32'h7FC00000, 32'h00000000}, // R6 NaN
        {4'd6,  3'd5, 32'h80000000, 32'h00000000}, // R6 negative zero
        {4'd7,  3'd3, 32'h00000001, 32'h00000094}, // R7 smallest subnormal
        {4'd7,  3'd0, 32'h00000001, 32'h3F000000}, // R7 smallest subnormal mantissa
        {4'd7,  3'd1, 32'h00400000, 32'h3F000000}, // R7 e=-127 odd
        {4'd7,  3'd4, 32'h00400000, 32'hFFFFFFC1}, // R7 floor(-127/2)+1
        {4'd7,  3'd2, 32'h00600000, 32'h3F400000}, // R7 log x1 of subnormal
        {4'd7,  3'd6, 32'h00600000, 32'hFFFFFF82}, // R7 log s of subnormal
        {4'd8,  3'd0, 32'h80000000, 32'h80000000}, // R8 negative zero
        {4'd8,  3'd1, 32'hFF800000, 32'hFF800000}, // R8 minus infinity
        {4'd8,  3'd2, 32'h7F800001, 32'h7FC00001}, // R8 signalling NaN
        {4'd8,  3'd0, 32'hFFA00000, 32'hFFE00000}, // R8 negative NaN
        {4'd9,  3'd7, 32'h3F800000, 32'h00000000}, // R9 unused code
        {4'd9,  3'd7, 32'h00000001, 32'h00000000}  // R9 unused code subnormal
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [31:0] opnd);
        @(negedge clk);
        valid_in   = 1'b1;
        op_sel     = op;
        operand_in = opnd;
        @(negedge clk);
        valid_in   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11", {31'd0, valid_out}, 32'd0);
        check("R11", result_out, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][66:64], VECS[i][63:32]);
            check($sformatf("R%0d", int'(VECS[i][70:67])), result_out, VECS[i][31:0]);
            check("R10", {31'd0, valid_out}, 32'd1);
        end

        // R10: idle cycles hold the result and drop valid
        apply(3'd0, 32'h40400000);
        held = result_out;
        check("R1", held, 32'h3F400000);
        operand_in = 32'h12345678;
        op_sel     = 3'd3;
        @(negedge clk);
        check("R10", {31'd0, valid_out}, 32'd0);
        check("R10", result_out, held);
        @(negedge clk);
        check("R10", result_out, held);

        // R10: back-to-back strobes give one result per cycle
        @(negedge clk);
        valid_in = 1'b1; op_sel = 3'd3; operand_in = 32'h3F800000;
        @(negedge clk);
        check("R10", result_out, 32'hFFFFFFFF);
        op_sel = 3'd4; operand_in = 32'h41000000;
        @(negedge clk);
        check("R10", result_out, 32'h00000002);
        check("R10", {31'd0, valid_out}, 32'd1);
        valid_in = 1'b0;
        @(negedge clk);
        check("R10", {31'd0, valid_out}, 32'd0);

        // R11 reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", result_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule